// File: doc/BRIEF.md
# Serial Command EEPROM Slave Engine

This block is the device side of a select-plus-three-wire serial memory. A system clock oversamples the select, serial clock and serial data-in pins. Each frame is decoded into one of seven commands: read, write, erase, write-all, erase-all, write-enable and write-disable. These act on an internal array of 256 words of 16 bits each. Reads stream the addressed word back on the data-out pin. Commands that change the array are only armed while select is high. They take effect when select falls, and a self-timed program cycle then starts. Its length in system clocks is a parameter.

While select is high, the data-out pin reports ready/busy status whenever no read is streaming. A write-enable latch guards every array change, and the latch comes up cleared. A host drives the pins as it would drive a discrete serial EEPROM. It raises select, clocks a frame in on rising serial-clock edges, drops select, and then polls status by raising select again.

Top module: `uw_eeprom`

## Requirements
- R1: While select is low, the output enable `sdo_oe_o` is 0 and `sdo_o` is 0. While select is high, the output enable is 1.
- R2: Zero bits clocked in before the first 1 are discarded. The frame starts at the first 1 bit, which is the start bit.
- R3: READ is start bit 1 followed by opcode 10 and 8 address bits, MSB first. After the last address bit, data-out shows one dummy 0. The next 16 rising serial-clock edges then each present one bit of the stored word, MSB first.
- R4: WRITE is opcode 01 with 8 address bits and 16 data bits, MSB first. It replaces the word when select falls, even if the word was not erased first.
- R5: ERASE is opcode 11 with 8 address bits. It sets the addressed word to 16'hFFFF.
- R6: With opcode 00, address bits A7:A6 pick the command: 11 is write-enable, 00 is write-disable, 01 is write-all (16 data bits follow, and every word takes them), and 10 is erase-all (every word becomes 16'hFFFF).
- R7: Write-enable is cleared at reset. WRITE, ERASE, write-all and erase-all leave the array unchanged and start no program cycle unless write-enable is set.
- R8: The program cycle starts on the select falling edge after an accepted array-changing command and lasts PROG_CYCLES clocks. With select high, data-out reads 0 while busy and 1 when idle.
- R9: A frame clocked in while a program cycle runs is ignored, including an erase.
- R10: If select falls before an array-changing frame is complete, the frame is discarded and no program cycle starts.
- R11: Serial clock and data-in activity while select is low has no effect.
- R12: After reset every word reads 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial data / ready-busy status to the host |
| sdo_oe_o | output | 1 | Output enable for `sdo_o`; 0 means high impedance |

## Verification
Two functions can land in the same stretch of time. One is the program timer counting down after a select fall. The other is the frame decoder seeing a complete new command. The bench provokes this by dropping select to launch a write, raising select again at once and clocking in a full erase of the same word well inside the busy window. It judges the result by first requiring data-out to read 0 during the window and 1 after it, then reading the word back and requiring the written value rather than 16'hFFFF. It also runs an aborted write and then raises select, where status must read ready at once.

// File: rtl/uw_pkg.sv
// Shared command type and decode helpers for the serial EEPROM engine.
package uw_pkg;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_READ,
        CMD_WRITE,
        CMD_ERASE,
        CMD_WEN,
        CMD_WDS,
        CMD_WRALL,
        CMD_ERAL
    } uw_cmd_e;

    // Map the two opcode bits and the two top address bits to a command.
    function automatic uw_cmd_e uw_decode(input logic [1:0] opc, input logic [1:0] top);
        uw_cmd_e c;
        case (opc)
            2'b10:   c = CMD_READ;
            2'b01:   c = CMD_WRITE;
            2'b11:   c = CMD_ERASE;
            default: begin
                case (top)
                    2'b11:   c = CMD_WEN;
                    2'b00:   c = CMD_WDS;
                    2'b01:   c = CMD_WRALL;
                    default: c = CMD_ERAL;
                endcase
            end
        endcase
        return c;
    endfunction

    // True for commands that change the array.
    function automatic logic uw_is_prog(input uw_cmd_e c);
        return (c == CMD_WRITE) || (c == CMD_ERASE) || (c == CMD_WRALL) || (c == CMD_ERAL);
    endfunction

endpackage

// File: rtl/uw_pin_sync.sv
// Synchronises the three serial pins into the system clock domain and
// produces one-cycle strobes for serial-clock rise (gated by select) and
// for select fall. Assumes each pin holds a level for several clocks.
module uw_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic sclk_i,
    input  logic sdi_i,
    output logic sel_o,
    output logic sdi_o,
    output logic sclk_rise_o,
    output logic sel_fall_o
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] sel_p;
    logic [TOP:0] sclk_p;
    logic [TOP:0] sdi_p;
    logic         sel_d;
    logic         sclk_d;

    // Shift each pin through the synchroniser chain and keep the last value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_p  <= '0;
            sclk_p <= '0;
            sdi_p  <= '0;
            sel_d  <= 1'b0;
            sclk_d <= 1'b0;
        end else begin
            sel_p  <= {sel_p[TOP-1:0], sel_i};
            sclk_p <= {sclk_p[TOP-1:0], sclk_i};
            sdi_p  <= {sdi_p[TOP-1:0], sdi_i};
            sel_d  <= sel_p[TOP];
            sclk_d <= sclk_p[TOP];
        end
    end

    assign sel_o       = sel_p[TOP];
    assign sdi_o       = sdi_p[TOP];
    assign sclk_rise_o = sclk_p[TOP] & ~sclk_d & sel_p[TOP];
    assign sel_fall_o  = ~sel_p[TOP] & sel_d;

endmodule

// File: rtl/uw_frame.sv
// Frame decoder: hunts for the start bit, collects opcode, address and
// data, issues a one-cycle request for non-read commands and streams the
// read word out. Assumes select low returns it to the hunt state.
module uw_frame
    import uw_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              sclk_rise_i,
    input  logic              sdi_i,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              req_o,
    output uw_cmd_e           req_cmd_o,
    output logic [DATA_W-1:0] req_data_o,
    output logic              read_active_o,
    output logic              sdo_bit_o
);
    localparam int MAXW  = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
    localparam int CNT_W = $clog2(MAXW);

    typedef enum logic [2:0] {F_HUNT, F_OPC, F_ADDR, F_DATA, F_READ, F_DONE} fstate_e;

    fstate_e           state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [1:0]        opc_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] shreg_q;
    logic              load_q;
    uw_cmd_e           cmd_q;
    logic [ADDR_W-1:0] addr_nx;
    uw_cmd_e           dec_nx;

    // Next address and the command it implies once the last bit arrives.
    always_comb begin
        addr_nx = {addr_q[ADDR_W-2:0], sdi_i};
        dec_nx  = uw_decode(opc_q, addr_nx[ADDR_W-1:ADDR_W-2]);
    end

    // Frame state machine, one step per gated serial-clock rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= F_HUNT;
            cnt_q     <= '0;
            opc_q     <= '0;
            addr_q    <= '0;
            shreg_q   <= '0;
            load_q    <= 1'b0;
            cmd_q     <= CMD_NONE;
            req_o     <= 1'b0;
            sdo_bit_o <= 1'b0;
        end else begin
            req_o <= 1'b0;
            if (load_q) begin
                shreg_q <= rd_data_i;
                load_q  <= 1'b0;
            end
            if (!sel_i) begin
                state_q   <= F_HUNT;
                load_q    <= 1'b0;
                sdo_bit_o <= 1'b0;
            end else if (sclk_rise_i) begin
                case (state_q)
                    F_HUNT: begin
                        if (sdi_i && !busy_i) begin
                            state_q <= F_OPC;
                            cnt_q   <= '0;
                        end
                    end
                    F_OPC: begin
                        opc_q <= {opc_q[0], sdi_i};
                        if (cnt_q == CNT_W'(1)) begin
                            state_q <= F_ADDR;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    F_ADDR: begin
                        addr_q <= addr_nx;
                        if (cnt_q == CNT_W'(ADDR_W - 1)) begin
                            cnt_q <= '0;
                            cmd_q <= dec_nx;
                            case (dec_nx)
                                CMD_READ: begin
                                    state_q   <= F_READ;
                                    sdo_bit_o <= 1'b0;
                                    load_q    <= 1'b1;
                                end
                                CMD_WRITE, CMD_WRALL: state_q <= F_DATA;
                                default: begin
                                    state_q <= F_DONE;
                                    req_o   <= 1'b1;
                                end
                            endcase
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    F_DATA: begin
                        shreg_q <= {shreg_q[DATA_W-2:0], sdi_i};
                        if (cnt_q == CNT_W'(DATA_W - 1)) begin
                            state_q <= F_DONE;
                            req_o   <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    F_READ: begin
                        sdo_bit_o <= shreg_q[DATA_W-1];
                        shreg_q   <= {shreg_q[DATA_W-2:0], 1'b0};
                    end
                    default: state_q <= F_DONE;
                endcase
            end
        end
    end

    assign addr_o        = addr_q;
    assign req_cmd_o     = cmd_q;
    assign req_data_o    = shreg_q;
    assign read_active_o = (state_q == F_READ);

endmodule

// File: rtl/uw_store.sv
// Word array, write-enable latch and self-timed program timer. Requests
// that change the array are armed only while enabled and idle, and are
// committed on the select falling edge. Assumes one request per frame.
module uw_store
    import uw_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  uw_cmd_e           req_cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] req_data_i,
    input  logic              sel_fall_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              busy_o,
    output logic              wen_o,
    output logic              wr_strobe_o
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int TMR_W = $clog2(PROG_CYCLES + 1);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic              wen_q;
    logic              armed_q;
    uw_cmd_e           pcmd_q;
    logic [ADDR_W-1:0] paddr_q;
    logic [DATA_W-1:0] pdata_q;
    logic              busy_q;
    logic [TMR_W-1:0]  left_q;
    logic              launch;
    logic              wr_all;
    logic [DATA_W-1:0] wr_val;

    // Launch condition and the value/scope of the pending change.
    always_comb begin
        launch = sel_fall_i & armed_q & ~busy_q;
        wr_all = (pcmd_q == CMD_WRALL) || (pcmd_q == CMD_ERAL);
        wr_val = ((pcmd_q == CMD_WRITE) || (pcmd_q == CMD_WRALL)) ? pdata_q : '1;
    end

    // Enable latch, arming of pending changes and the program timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wen_q   <= 1'b0;
            armed_q <= 1'b0;
            pcmd_q  <= CMD_NONE;
            paddr_q <= '0;
            pdata_q <= '0;
            busy_q  <= 1'b0;
            left_q  <= '0;
        end else begin
            if (req_i && !busy_q) begin
                if (req_cmd_i == CMD_WEN) begin
                    wen_q <= 1'b1;
                end else if (req_cmd_i == CMD_WDS) begin
                    wen_q <= 1'b0;
                end else if (uw_is_prog(req_cmd_i) && wen_q) begin
                    armed_q <= 1'b1;
                    pcmd_q  <= req_cmd_i;
                    paddr_q <= addr_i;
                    pdata_q <= req_data_i;
                end
            end
            if (sel_fall_i) begin
                armed_q <= 1'b0;
            end
            if (launch) begin
                busy_q <= 1'b1;
                left_q <= TMR_W'(PROG_CYCLES - 1);
            end else if (busy_q) begin
                if (left_q == '0) begin
                    busy_q <= 1'b0;
                end else begin
                    left_q <= left_q - 1'b1;
                end
            end
        end
    end

    // Array storage: erased at reset, updated at program launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '1;
            end
        end else if (launch) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_all || (paddr_q == ADDR_W'(i))) begin
                    mem_q[i] <= wr_val;
                end
            end
        end
    end

    assign rd_data_o   = mem_q[addr_i];
    assign busy_o      = busy_q;
    assign wen_o       = wen_q;
    assign wr_strobe_o = launch;

endmodule

// File: rtl/uw_eeprom.sv
// Top of the serial EEPROM slave engine: pin synchroniser, frame decoder,
// storage with program timer, and the registered data-out/enable pair.
// Assumes the host holds each serial level for several system clocks.
module uw_eeprom
    import uw_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 400,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic sclk_i,
    input  logic sdi_i,
    output logic sdo_o,
    output logic sdo_oe_o
);
    logic              sel_w;
    logic              sdi_w;
    logic              sclk_rise_w;
    logic              sel_fall_w;
    logic              busy_w;
    logic              wen_w;
    logic              wr_strobe_w;
    logic              req_w;
    uw_cmd_e           req_cmd_w;
    logic [ADDR_W-1:0] addr_w;
    logic [DATA_W-1:0] req_data_w;
    logic [DATA_W-1:0] rd_data_w;
    logic              read_active_w;
    logic              sdo_bit_w;

    uw_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_i       (sel_i),
        .sclk_i      (sclk_i),
        .sdi_i       (sdi_i),
        .sel_o       (sel_w),
        .sdi_o       (sdi_w),
        .sclk_rise_o (sclk_rise_w),
        .sel_fall_o  (sel_fall_w)
    );

    uw_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
        .clk           (clk),
        .rst_n         (rst_n),
        .sel_i         (sel_w),
        .sclk_rise_i   (sclk_rise_w),
        .sdi_i         (sdi_w),
        .busy_i        (busy_w),
        .rd_data_i     (rd_data_w),
        .addr_o        (addr_w),
        .req_o         (req_w),
        .req_cmd_o     (req_cmd_w),
        .req_data_o    (req_data_w),
        .read_active_o (read_active_w),
        .sdo_bit_o     (sdo_bit_w)
    );

    uw_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_w),
        .req_cmd_i   (req_cmd_w),
        .addr_i      (addr_w),
        .req_data_i  (req_data_w),
        .sel_fall_i  (sel_fall_w),
        .rd_data_o   (rd_data_w),
        .busy_o      (busy_w),
        .wen_o       (wen_w),
        .wr_strobe_o (wr_strobe_w)
    );

    // Drive data-out: read stream, else inverted busy; quiet when deselected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo_o    <= 1'b0;
            sdo_oe_o <= 1'b0;
        end else begin
            sdo_oe_o <= sel_w;
            if (!sel_w) begin
                sdo_o <= 1'b0;
            end else if (read_active_w) begin
                sdo_o <= sdo_bit_w;
            end else begin
                sdo_o <= ~busy_w;
            end
        end
    end

endmodule

// File: rtl/uw_eeprom_chk.sv
// Protocol checker bound to the engine top; watches select, timer status,
// the enable latch and data-out.
module uw_eeprom_chk (
    input logic clk,
    input logic rst_n,
    input logic sel_q,
    input logic sel_fall,
    input logic busy,
    input logic wen,
    input logic wr_strobe,
    input logic sdo,
    input logic sdo_oe
);
    assert_hiz_when_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sel_q) |-> (!sdo_oe && !sdo));

    assert_prog_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> wen);

    assert_busy_starts_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(sel_fall));

    assert_busy_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> !sdo);

    assert_no_strobe_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_strobe);
endmodule

bind uw_eeprom uw_eeprom_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_q     (sel_w),
    .sel_fall  (sel_fall_w),
    .busy      (busy_w),
    .wen       (wen_w),
    .wr_strobe (wr_strobe_w),
    .sdo       (sdo_o),
    .sdo_oe    (sdo_oe_o)
);

// File: tb/uw_eeprom_bench.sv
module uw_eeprom_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int PROG       = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdo;
    logic sdo_oe;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] model [256];

    always #(CLK_PERIOD / 2) clk = ~clk;

    uw_eeprom #(.PROG_CYCLES(PROG)) u_uw_eeprom (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (sel),
        .sclk_i   (sclk),
        .sdi_i    (sdi),
        .sdo_o    (sdo),
        .sdo_oe_o (sdo_oe)
    );

    function automatic logic [15:0] expect_word(input bit erase, input logic [15:0] d);
        return erase ? 16'hFFFF : d;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bit_out(input logic b);
        sdi = b;
        tick(HALF);
        sclk = 1'b1;
        tick(HALF);
        sclk = 1'b0;
    endtask

    task automatic sel_up();
        sel = 1'b1;
        tick(HALF);
    endtask

    task automatic sel_down();
        sclk = 1'b0;
        sel  = 1'b0;
        tick(HALF);
    endtask

    task automatic send_head(input logic [1:0] op, input logic [7:0] a, input int lead);
        for (int i = 0; i < lead; i++) bit_out(1'b0);
        bit_out(1'b1);
        bit_out(op[1]);
        bit_out(op[0]);
        for (int i = 7; i >= 0; i--) bit_out(a[i]);
    endtask

    task automatic cmd_frame(input logic [1:0] op, input logic [7:0] a, input bit has_data, input logic [15:0] d);
        sel_up();
        send_head(op, a, $urandom_range(0, 3));
        if (has_data) begin
            for (int i = 15; i >= 0; i--) bit_out(d[i]);
        end
        sel_down();
    endtask

    task automatic prog_wait(input string req);
        sel_up();
        tick(2);
        check(sdo_oe == 1'b1 && sdo == 1'b0, req, {15'b0, sdo}, 16'h0000);
        tick(PROG + 20);
        check(sdo == 1'b1, req, {15'b0, sdo}, 16'h0001);
        sel_down();
    endtask

    task automatic read_word(input logic [7:0] a, input logic [15:0] exp, input string req);
        logic [15:0] got;
        got = '0;
        sel_up();
        send_head(2'b10, a, $urandom_range(0, 3));
        check(sdo == 1'b0, "R3 dummy bit", {15'b0, sdo}, 16'h0000);
        for (int i = 15; i >= 0; i--) begin
            bit_out(1'b0);
            got[i] = sdo;
        end
        sel_down();
        check(got == exp, req, got, exp);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) model[i] = 16'hFFFF;
        tick(5);
        rst_n = 1'b1;
        tick(3);

        // R1: deselected after reset
        check(sdo_oe == 1'b0 && sdo == 1'b0, "R1 reset hiz", {14'b0, sdo_oe, sdo}, 16'h0000);
        // R12 / R3: erased array after reset
        read_word(8'd5, 16'hFFFF, "R12 reset content");

        // R11: a write-enable frame clocked while deselected is ignored
        send_head(2'b00, 8'hC0, 0);
        // R7: write while disabled does nothing
        cmd_frame(2'b01, 8'd5, 1'b1, 16'h1234);
        sel_up();
        tick(2);
        check(sdo == 1'b1, "R7 no busy when disabled", {15'b0, sdo}, 16'h0001);
        sel_down();
        read_word(8'd5, 16'hFFFF, "R11 R7 word unchanged");
        check(sdo_oe == 1'b0 && sdo == 1'b0, "R1 deselected", {14'b0, sdo_oe, sdo}, 16'h0000);

        // R6 enable, R4 write and overwrite, R8 busy status
        cmd_frame(2'b00, 8'hC0, 1'b0, 16'h0);
        cmd_frame(2'b01, 8'd5, 1'b1, 16'hA5C3);
        prog_wait("R8 busy/ready after write");
        model[5] = expect_word(1'b0, 16'hA5C3);
        read_word(8'd5, model[5], "R4 write");
        cmd_frame(2'b01, 8'd5, 1'b1, 16'h0F0F);
        prog_wait("R8 busy/ready after overwrite");
        model[5] = expect_word(1'b0, 16'h0F0F);
        read_word(8'd5, model[5], "R4 overwrite without erase");

        // R5 erase
        cmd_frame(2'b11, 8'd5, 1'b0, 16'h0);
        prog_wait("R8 busy/ready after erase");
        model[5] = expect_word(1'b1, 16'h0);
        read_word(8'd5, model[5], "R5 erase");

        // R9: erase clocked in during the busy window of a write
        cmd_frame(2'b01, 8'd9, 1'b1, 16'h1111);
        sel_up();
        send_head(2'b11, 8'd9, 1);
        sel_down();
        prog_wait("R8 ready after busy frame");
        model[9] = 16'h1111;
        read_word(8'd9, model[9], "R9 erase during busy ignored");

        // R10: aborted write frame
        sel_up();
        send_head(2'b01, 8'd9, 0);
        for (int i = 0; i < 10; i++) bit_out(1'b1);
        sel_down();
        sel_up();
        tick(2);
        check(sdo == 1'b1, "R10 no program after abort", {15'b0, sdo}, 16'h0001);
        sel_down();
        read_word(8'd9, model[9], "R10 aborted write");

        // R6 write-all and erase-all
        cmd_frame(2'b00, 8'h40, 1'b1, 16'h3C3C);
        prog_wait("R8 busy/ready after write-all");
        for (int i = 0; i < 256; i++) model[i] = 16'h3C3C;
        read_word(8'd0, model[0], "R6 write-all low");
        read_word(8'd255, model[255], "R6 write-all high");
        cmd_frame(2'b00, 8'h80, 1'b0, 16'h0);
        prog_wait("R8 busy/ready after erase-all");
        for (int i = 0; i < 256; i++) model[i] = 16'hFFFF;
        read_word(8'd128, model[128], "R6 erase-all");

        // R6 write-disable, then R7 write ignored
        cmd_frame(2'b00, 8'h00, 1'b0, 16'h0);
        cmd_frame(2'b01, 8'd3, 1'b1, 16'h5555);
        read_word(8'd3, model[3], "R7 write after disable ignored");

        // Random traffic with random leading zeros (R2)
        cmd_frame(2'b00, 8'hC0, 1'b0, 16'h0);
        for (int k = 0; k < 14; k++) begin
            logic [7:0]  a;
            logic [15:0] d;
            bit          er;
            a  = 8'($urandom_range(0, 255));
            d  = 16'($urandom);
            er = ($urandom_range(0, 3) == 0);
            if (er) cmd_frame(2'b11, a, 1'b0, 16'h0);
            else    cmd_frame(2'b01, a, 1'b1, d);
            prog_wait("R8 random program");
            model[a] = expect_word(er, d);
            read_word(a, model[a], "R2 R4 R5 random");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule